// File: doc/BRIEF.md
# ADC Bring-Up Sequencer

This block runs the power-on handshake of an external serial converter that returns a 12-bit value plus a sign bit. After a start request it sends a self-calibration command and then a status read whose data it throws away. It waits for a rising edge on the end-of-conversion line and reads status again. If the calibration-busy flag has cleared, it sends the command that picks one of four sample-and-hold acquisition windows. The host sees a done level, an error flag with a cause code, a timeout flag and the last status word. All of these hold until the next start.

Transfers go through a byte-wide serial master that sits next to the block. The block puts a command byte on `spi_tx_o`, pulses `spi_req_o` for one cycle and waits for `spi_done_i`. `spi_two_o` asks for two returned bytes instead of one. On the converter variant with fewer channels, every command byte is repacked before it leaves the block.

Top module: `adc_bringup_seq`

## Requirements
- R1: After reset `done_o`, `err_o`, `eoc_tmo_o` and `spi_req_o` are 0, `err_code_o` is 0 and `status_o` is 0.
- R2: A start request produces transfers in this order: calibrate 0x08 as one byte (`spi_two_o`=0), status 0x0C as two bytes, a wait for end of conversion, then status 0x0C as two bytes again. On success a fourth one-byte transfer carries the acquisition command.
- R3: The acquisition command byte is 0x0E for 6 cycles, 0x4E for 10, 0x8E for 18 and 0xCE for 34. When `acq_set_i` is 0 at start, 10 cycles (0x4E) are used.
- R4: A requested acquisition value other than 6, 10, 18 or 34 ends the run with `err_o`=1 and `err_code_o`=2, and no acquisition transfer is sent (three transfers in total).
- R5: `status_o` equals {first received byte, bit 7 of the second received byte} from the second status read. The data of the throwaway status read has no effect on the result.
- R6: If bit 6 of the status word is 1 (bit 5 of the first received byte), the run ends with `err_o`=1 and `err_code_o`=1, and no acquisition transfer is sent.
- R7: With `compact_i`=1, every command byte b is sent as {b[7:6], b[3:0], 2'b00}. Calibrate becomes 0x20, status 0x30 and acquisition for 34 cycles 0xF8.
- R8: A rising edge on `eoc_i` ends the wait only if it comes after the calibration command has been issued. An edge during the throwaway read still counts. An edge while idle is ignored.
- R9: If no edge arrives within TIMEOUT_CYC cycles of the calibration command, `eoc_tmo_o` becomes 1 and the sequence goes on with the second status read. The run is not aborted.
- R10: `done_o`, `err_o`, `err_code_o` and `eoc_tmo_o` hold until the next start request, which clears them. A start request during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to run the bring-up sequence |
| compact_i | input | 1 | 1 selects command repacking for the reduced-channel converter |
| acq_set_i | input | 1 | 1 when `acq_cycles_i` carries a requested acquisition time |
| acq_cycles_i | input | ACQ_W | Requested acquisition time in conversion-clock periods |
| eoc_i | input | 1 | End-of-conversion line from the converter (asynchronous) |
| spi_done_i | input | 1 | Serial master finished the current transfer |
| spi_rx0_i | input | 8 | First byte received in the transfer |
| spi_rx1_i | input | 8 | Second byte received in the transfer |
| spi_req_o | output | 1 | One-cycle transfer request |
| spi_tx_o | output | 8 | Command byte, held until `spi_done_i` |
| spi_two_o | output | 1 | 1 requests two received bytes, 0 one |
| done_o | output | 1 | Sequence finished, held |
| err_o | output | 1 | Sequence failed, held |
| err_code_o | output | 2 | 0 ok, 1 calibration still busy, 2 bad acquisition value |
| eoc_tmo_o | output | 1 | End-of-conversion wait timed out |
| status_o | output | 9 | Status word from the confirming read |

## Verification
The bench builds the block with TIMEOUT_CYC set to 40. This brings the no-edge path of R9 within a few dozen cycles, and edges at 5 and 20 cycles after calibration land inside the window. It keeps SYNC_STAGES at 2 and ACQ_W at 6, so the invalid value 12 and all four valid codes can be requested. A behavioural serial master answers each request three cycles later and returns all-ones data on the throwaway read. A flag with the busy bit set therefore shows that this data is ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CAL_TX, S_CAL_WT, S_DMY_TX, S_DMY_WT, S_EOC_WT,
    S_STA_TX, S_STA_WT, S_ACQ_CHK, S_ACQ_TX, S_ACQ_WT, S_END
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_CAL_BUSY = 2'd1,
    RES_BAD_ACQ  = 2'd2
  } seq_res_e;

  localparam logic [7:0] CMD_CAL  = 8'h08;
  localparam logic [7:0] CMD_STAT = 8'h0C;
  localparam int unsigned STAT_BUSY_BIT = 6;

endpackage

// File: rtl/adc_seq_cmd_pack.sv
module adc_seq_cmd_pack (
  input  logic       compact_i,
  input  logic [7:0] cmd_i,
  output logic [7:0] cmd_o
);
  // reduced-channel part has no use for bits 5:4; low nibble shifts up
  always_comb begin
    if (compact_i) cmd_o = {cmd_i[7:6], cmd_i[3:0], 2'b00};
    else           cmd_o = cmd_i;
  end
endmodule

// File: rtl/adc_seq_acq_map.sv
module adc_seq_acq_map #(
  parameter int unsigned ACQ_W       = 6,
  parameter int unsigned DEFAULT_ACQ = 10
) (
  input  logic             acq_set_i,
  input  logic [ACQ_W-1:0] acq_cycles_i,
  output logic [7:0]       code_o,
  output logic             ok_o
);
  logic [ACQ_W-1:0] sel;

  assign sel = acq_set_i ? acq_cycles_i : ACQ_W'(DEFAULT_ACQ);

  always_comb begin
    ok_o   = 1'b1;
    code_o = 8'h00;
    case (sel)
      ACQ_W'(6):  code_o = 8'h0E;
      ACQ_W'(10): code_o = 8'h4E;
      ACQ_W'(18): code_o = 8'h8E;
      ACQ_W'(34): code_o = 8'hCE;
      default:    ok_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_seq_eoc_watch.sv
module adc_seq_eoc_watch #(
  parameter int unsigned TIMEOUT_CYC = 10_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic eoc_i,
  output logic seen_o,
  output logic tmo_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;
  logic                   running_q;
  logic [CW-1:0]          cnt_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= eoc_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], eoc_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // edges count only while armed; arming restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      seen_o    <= 1'b0;
      tmo_o     <= 1'b0;
      cnt_q     <= '0;
    end else if (arm_i) begin
      running_q <= 1'b1;
      seen_o    <= 1'b0;
      tmo_o     <= 1'b0;
      cnt_q     <= '0;
    end else if (running_q) begin
      if (rise) begin
        seen_o    <= 1'b1;
        running_q <= 1'b0;
      end else if (cnt_q == CW'(TIMEOUT_CYC - 1)) begin
        tmo_o     <= 1'b1;
        running_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 10_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEFAULT_ACQ = 10,
  parameter int unsigned ACQ_W       = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             compact_i,
  input  logic             acq_set_i,
  input  logic [ACQ_W-1:0] acq_cycles_i,
  input  logic             eoc_i,
  input  logic             spi_done_i,
  input  logic [7:0]       spi_rx0_i,
  input  logic [7:0]       spi_rx1_i,
  output logic             spi_req_o,
  output logic [7:0]       spi_tx_o,
  output logic             spi_two_o,
  output logic             done_o,
  output logic             err_o,
  output logic [1:0]       err_code_o,
  output logic             eoc_tmo_o,
  output logic [8:0]       status_o
);
  seq_state_e       state_q;
  logic             compact_q, acq_set_q;
  logic [ACQ_W-1:0] acq_q;
  logic [7:0]       acq_code, raw_cmd;
  logic             acq_ok, arm, eoc_seen, eoc_tmo;
  logic             accept;

  adc_seq_acq_map #(.ACQ_W(ACQ_W), .DEFAULT_ACQ(DEFAULT_ACQ)) u_acq (
    .acq_set_i   (acq_set_q),
    .acq_cycles_i(acq_q),
    .code_o      (acq_code),
    .ok_o        (acq_ok)
  );

  adc_seq_eoc_watch #(.TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_eoc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (arm),
    .eoc_i (eoc_i),
    .seen_o(eoc_seen),
    .tmo_o (eoc_tmo)
  );

  adc_seq_cmd_pack u_pack (
    .compact_i(compact_q),
    .cmd_i    (raw_cmd),
    .cmd_o    (spi_tx_o)
  );

  assign accept = start_i && (state_q == S_IDLE || state_q == S_END);
  assign arm    = (state_q == S_CAL_TX);

  always_comb begin
    unique case (state_q)
      S_CAL_TX, S_CAL_WT:                     raw_cmd = CMD_CAL;
      S_DMY_TX, S_DMY_WT, S_STA_TX, S_STA_WT: raw_cmd = CMD_STAT;
      S_ACQ_TX, S_ACQ_WT:                     raw_cmd = acq_code;
      default:                                raw_cmd = 8'h00;
    endcase
  end

  assign spi_req_o = (state_q == S_CAL_TX) || (state_q == S_DMY_TX) ||
                     (state_q == S_STA_TX) || (state_q == S_ACQ_TX);
  assign spi_two_o = (state_q == S_DMY_TX) || (state_q == S_DMY_WT) ||
                     (state_q == S_STA_TX) || (state_q == S_STA_WT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      compact_q  <= 1'b0;
      acq_set_q  <= 1'b0;
      acq_q      <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_code_o <= RES_OK;
      eoc_tmo_o  <= 1'b0;
      status_o   <= '0;
    end else if (accept) begin
      state_q    <= S_CAL_TX;
      compact_q  <= compact_i;
      acq_set_q  <= acq_set_i;
      acq_q      <= acq_cycles_i;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_code_o <= RES_OK;
      eoc_tmo_o  <= 1'b0;
    end else begin
      unique case (state_q)
        S_CAL_TX: state_q <= S_CAL_WT;
        S_CAL_WT: if (spi_done_i) state_q <= S_DMY_TX;
        S_DMY_TX: state_q <= S_DMY_WT;
        S_DMY_WT: if (spi_done_i) state_q <= S_EOC_WT;  // data discarded
        S_EOC_WT: begin
          if (eoc_seen || eoc_tmo) begin
            eoc_tmo_o <= eoc_tmo & ~eoc_seen;
            state_q   <= S_STA_TX;
          end
        end
        S_STA_TX: state_q <= S_STA_WT;
        S_STA_WT: begin
          if (spi_done_i) begin
            status_o <= {spi_rx0_i, spi_rx1_i[7]};
            state_q  <= S_ACQ_CHK;
          end
        end
        S_ACQ_CHK: begin
          if (status_o[STAT_BUSY_BIT]) begin
            err_o <= 1'b1; err_code_o <= RES_CAL_BUSY; done_o <= 1'b1;
            state_q <= S_END;
          end else if (!acq_ok) begin
            err_o <= 1'b1; err_code_o <= RES_BAD_ACQ; done_o <= 1'b1;
            state_q <= S_END;
          end else begin
            state_q <= S_ACQ_TX;
          end
        end
        S_ACQ_TX: state_q <= S_ACQ_WT;
        S_ACQ_WT: begin
          if (spi_done_i) begin
            done_o  <= 1'b1;
            state_q <= S_END;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_bringup_seq_chk.sv
module adc_bringup_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       compact_i,
  input logic       spi_req_o,
  input logic [7:0] spi_tx_o,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] err_code_o
);
  // R2: each transfer request lasts one cycle
  a_r2_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_req_o |=> !spi_req_o);

  // R7: repacked commands have zero low bits
  a_r7_pack_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (compact_i && spi_req_o) |-> (spi_tx_o[1:0] == 2'b00));

  // R10: result holds while no start arrives
  a_r10_done_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  // R10: start clears result
  a_r10_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (!done_o && !err_o));

  // R4: error flag agrees with cause code
  a_r4_code_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o == (err_code_o != 2'd0)));

  // R6: no traffic once finished
  a_r6_quiet_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !spi_req_o);
endmodule

bind adc_bringup_seq adc_bringup_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .compact_i (compact_i),
  .spi_req_o (spi_req_o),
  .spi_tx_o  (spi_tx_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .err_code_o(err_code_o)
);

// File: tb/adc_bringup_seq_bench.sv
`timescale 1ns/1ps
module adc_bringup_seq_bench;

  localparam int unsigned TMO = 40;

  typedef struct packed {
    logic       compact;
    logic       aset;
    logic [5:0] acq;
    logic [7:0] s0;
    logic [7:0] s1;
    logic [7:0] eoc_at;
    logic [1:0] code;
    logic       tmo;
    logic [3:0] ntx;
    logic [7:0] last;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 6'd6,  8'h00, 8'h00, 8'd20, 2'd0, 1'b0, 4'd4, 8'h0E},
    '{1'b0, 1'b1, 6'd10, 8'h12, 8'h80, 8'd20, 2'd0, 1'b0, 4'd4, 8'h4E},
    '{1'b0, 1'b1, 6'd18, 8'h9F, 8'h00, 8'd20, 2'd0, 1'b0, 4'd4, 8'h8E},
    '{1'b0, 1'b1, 6'd34, 8'h01, 8'h7F, 8'd20, 2'd0, 1'b0, 4'd4, 8'hCE},
    '{1'b0, 1'b0, 6'd0,  8'h00, 8'h00, 8'd20, 2'd0, 1'b0, 4'd4, 8'h4E},
    '{1'b0, 1'b1, 6'd12, 8'h00, 8'h00, 8'd20, 2'd2, 1'b0, 4'd3, 8'h0C},
    '{1'b0, 1'b1, 6'd6,  8'h20, 8'h80, 8'd20, 2'd1, 1'b0, 4'd3, 8'h0C},
    '{1'b1, 1'b1, 6'd34, 8'h00, 8'h00, 8'd20, 2'd0, 1'b0, 4'd4, 8'hF8},
    '{1'b1, 1'b0, 6'd0,  8'h00, 8'h00, 8'd20, 2'd0, 1'b0, 4'd4, 8'h78},
    '{1'b0, 1'b1, 6'd6,  8'h00, 8'h00, 8'd0,  2'd0, 1'b1, 4'd4, 8'h0E},
    '{1'b0, 1'b1, 6'd6,  8'h00, 8'h00, 8'd5,  2'd0, 1'b0, 4'd4, 8'h0E},
    '{1'b1, 1'b1, 6'd6,  8'h20, 8'h00, 8'd20, 2'd1, 1'b0, 4'd3, 8'h30}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       compact_i = 1'b0;
  logic       acq_set_i = 1'b0;
  logic [5:0] acq_cycles_i = '0;
  logic       eoc_i;
  logic       spi_done_i;
  logic [7:0] spi_rx0_i, spi_rx1_i;
  logic       spi_req_o, spi_two_o, done_o, err_o, eoc_tmo_o;
  logic [7:0] spi_tx_o;
  logic [1:0] err_code_o;
  logic [8:0] status_o;

  int n_chk = 0;
  int n_bad = 0;

  // serial master and converter model
  logic       clr = 1'b0;
  logic       eoc_man = 1'b0;
  logic       eoc_m;
  logic [7:0] cfg_s0 = '0, cfg_s1 = '0, cfg_eoc = '0;
  logic [7:0] log_tx [8];
  logic       log_two [8];
  int         ntx;
  int         rsp_cnt, eoc_cnt, eoc_hold;
  logic       pend;

  assign eoc_i = eoc_m | eoc_man;

  always #2 clk_i = ~clk_i;

  adc_bringup_seq #(.TIMEOUT_CYC(TMO)) u_adc_bringup_seq (
    .clk_i, .rst_ni, .start_i, .compact_i, .acq_set_i, .acq_cycles_i,
    .eoc_i, .spi_done_i, .spi_rx0_i, .spi_rx1_i,
    .spi_req_o, .spi_tx_o, .spi_two_o, .done_o, .err_o, .err_code_o,
    .eoc_tmo_o, .status_o
  );

  always @(posedge clk_i) begin
    spi_done_i <= 1'b0;
    if (clr) begin
      ntx <= 0; pend <= 1'b0; eoc_cnt <= 0; eoc_hold <= 0; eoc_m <= 1'b0;
      spi_rx0_i <= '0; spi_rx1_i <= '0; rsp_cnt <= 0;
    end else begin
      if (spi_req_o) begin
        if (ntx < 8) begin
          log_tx[ntx]  <= spi_tx_o;
          log_two[ntx] <= spi_two_o;
        end
        if (ntx == 0) eoc_cnt <= int'(cfg_eoc);
        if (ntx == 1) begin spi_rx0_i <= 8'hFF; spi_rx1_i <= 8'hFF; end
        else if (ntx == 2) begin spi_rx0_i <= cfg_s0; spi_rx1_i <= cfg_s1; end
        else begin spi_rx0_i <= 8'h00; spi_rx1_i <= 8'h00; end
        ntx <= ntx + 1; pend <= 1'b1; rsp_cnt <= 3;
      end else if (pend) begin
        if (rsp_cnt == 1) begin spi_done_i <= 1'b1; pend <= 1'b0; end
        rsp_cnt <= rsp_cnt - 1;
      end
      if (eoc_cnt > 1) eoc_cnt <= eoc_cnt - 1;
      else if (eoc_cnt == 1) begin eoc_cnt <= 0; eoc_hold <= 4; eoc_m <= 1'b1; end
      if (eoc_hold > 1) eoc_hold <= eoc_hold - 1;
      else if (eoc_hold == 1) begin eoc_hold <= 0; eoc_m <= 1'b0; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reset_model();
    @(negedge clk_i); clr = 1'b1;
    @(negedge clk_i); clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk_i);
      if (done_o) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    bit ok;
    logic [7:0] cal_b, st_b;
    cal_b = v.compact ? 8'h20 : 8'h08;
    st_b  = v.compact ? 8'h30 : 8'h0C;
    cfg_s0 = v.s0; cfg_s1 = v.s1; cfg_eoc = v.eoc_at;
    compact_i = v.compact; acq_set_i = v.aset; acq_cycles_i = v.acq;
    reset_model();
    pulse_start();
    wait_done(ok);
    repeat (6) @(negedge clk_i);
    $display("vector %0d", idx);
    chk("R2 done reached", 32'(ok), 32'd1);
    chk("R4/R6 err_code", 32'(err_code_o), 32'(v.code));
    chk("R4/R6 err flag", 32'(err_o), 32'(v.code != 2'd0));
    chk("R9 timeout flag", 32'(eoc_tmo_o), 32'(v.tmo));
    chk("R2/R4/R6 transfer count", 32'(ntx), 32'(v.ntx));
    chk("R2/R7 first cmd", {23'd0, log_two[0], log_tx[0]}, {23'd0, 1'b0, cal_b});
    chk("R2/R7 dummy read", {23'd0, log_two[1], log_tx[1]}, {23'd0, 1'b1, st_b});
    chk("R2/R7 status read", {23'd0, log_two[2], log_tx[2]}, {23'd0, 1'b1, st_b});
    if (v.ntx == 4)
      chk("R3/R7 acq cmd", {23'd0, log_two[3], log_tx[3]}, {23'd0, 1'b0, v.last});
    chk("R5 status word", 32'(status_o), {23'd0, v.s0, v.s1[7]});
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog R10 act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    bit ok;
    clr = 1'b1;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 done", 32'(done_o), 0);
    chk("R1 err", 32'(err_o), 0);
    chk("R1 req", 32'(spi_req_o), 0);
    chk("R1 code/tmo/status", {20'd0, err_code_o, eoc_tmo_o, status_o}, 0);
    rst_ni = 1'b1;
    clr = 1'b0;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R8: an edge while idle is not remembered
    reset_model();
    eoc_man = 1'b1; repeat (5) @(negedge clk_i); eoc_man = 1'b0;
    repeat (5) @(negedge clk_i);
    cfg_eoc = 8'd0; cfg_s0 = 8'h00; cfg_s1 = 8'h00;
    compact_i = 1'b0; acq_set_i = 1'b1; acq_cycles_i = 6'd6;
    pulse_start();
    wait_done(ok);
    chk("R8 idle edge ignored -> timeout", 32'(eoc_tmo_o), 32'd1);
    chk("R9 continues after timeout", 32'(ntx), 32'd4);

    // R10: start during a run is ignored
    reset_model();
    cfg_eoc = 8'd20;
    pulse_start();
    repeat (4) @(negedge clk_i);
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    wait_done(ok);
    repeat (6) @(negedge clk_i);
    chk("R10 busy start ignored count", 32'(ntx), 32'd4);
    chk("R10 single calibration", 32'(log_tx[1]), 32'h0C);

    // R10: results held, then cleared by start
    repeat (30) @(negedge clk_i);
    chk("R10 done held", 32'(done_o), 32'd1);
    reset_model();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk("R10 start clears done", 32'(done_o), 32'd0);
    wait_done(ok);
    chk("R10 second run completes", 32'(ok), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule